// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block turns a 39-bit virtual address into a physical address by reading up to three page table entries from memory. A translation request carries the virtual address. At the moment the request is accepted the walker also samples a control word: a 4-bit translation mode, an address-space identifier and the physical page number of the root table. In Sv39 mode it reads one 8-byte entry per level over a request/response memory port, and it never has more than one read in flight. Each entry either points to the next table or is a leaf.

A walk ends with a single-cycle result. The result carries the physical address, the final entry, the level at which the walk stopped and the sampled identifier. If the walk fails, the result reports a page fault together with the level of the offending entry. A leaf found above the last level ends the walk early with a 2 MiB or 1 GiB page. The walker does not check leaf permissions, fill a TLB or write back the accessed or dirty bits; other blocks do that work.

Top module: `sv39_walker`

## Requirements
- R1: Mode value 0 (bare) gives a result with res_fault=0, res_level=0, res_pte=0 and res_paddr equal to the virtual address zero-extended. It issues no memory read.
- R2: Any mode value other than 0 or 8 gives a result with res_fault=1 and res_badmode=1, with res_paddr, res_pte and res_level all zero. It issues no memory read.
- R3: Mode 8 starts at level 2. The first entry address is the root page number shifted left by 12, plus VA[38:30]×8. Every entry address is the table base plus the 9-bit index×8, so it is 8-byte aligned. Level 1 takes its index from VA[29:21] and level 0 from VA[20:12].
- R4: Entry bits are V=bit 0, R=bit 1, W=bit 2, X=bit 3, and the page number is bits 53:10. A valid entry at level 2 or 1 with X=W=R=0 is a pointer. The next table base is its page number shifted left by 12, and the walk moves down one level.
- R5: A valid leaf at level 0 gives res_paddr = {page number, VA[11:0]}, res_level=0, res_fault=0, and res_pte equal to the entry.
- R6: A valid, aligned leaf at level 1 gives res_paddr = {page number[43:9], VA[20:0]}. At level 2 it gives {page number[43:18], VA[29:0]}. res_level reports the leaf level.
- R7: An entry with V=0 ends the walk with res_fault=1, res_level set to that entry's level, res_pte equal to the entry and res_paddr=0.
- R8: An entry whose {X,W,R} field is 010 or 110 is reserved. It raises a fault at its level.
- R9: A pointer entry at level 0 raises a fault at level 0.
- R10: A level-1 leaf with a non-zero page number[8:0] is misaligned and raises a fault, and so is a level-2 leaf with a non-zero page number[17:0].
- R11: At most one memory read is outstanding at any time. A read request holds its address until the memory accepts it.
- R12: The mode, identifier and root page number are sampled only when a request is accepted. A new request can be accepted in the same cycle in which the previous result is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request this cycle |
| req_vaddr | input | 39 | Virtual address to translate |
| ctl_mode | input | 4 | Translation mode (0 bare, 8 Sv39) |
| ctl_asid | input | ASID_W | Address-space identifier |
| ctl_root_ppn | input | PA_W-12 | Root table physical page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry read from memory |
| res_valid | output | 1 | Result present for one cycle |
| res_fault | output | 1 | Page fault |
| res_badmode | output | 1 | Fault caused by an unsupported mode |
| res_level | output | 2 | Level of the final entry |
| res_paddr | output | PA_W | Translated physical address |
| res_pte | output | 64 | Final entry read |
| res_asid | output | ASID_W | Identifier sampled with the request |

## Verification
Two things can happen in the same cycle: the result of one walk is presented, and the next request is accepted. The bench keeps req_valid high for a second request, with different control values, while the first walk is still in progress. The second request is therefore accepted in the first walk's result cycle. The bench records that overlap. It then requires both results to come out in order with their own values, which shows that control changes during a walk have no effect.

// File: rtl/sv39_walker.sv
module sv39_walker #(
  parameter int ASID_W = 16,
  parameter int PA_W   = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [38:0]       req_vaddr,
  input  logic [3:0]        ctl_mode,
  input  logic [ASID_W-1:0] ctl_asid,
  input  logic [PA_W-13:0]  ctl_root_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic              res_badmode,
  output logic [1:0]        res_level,
  output logic [PA_W-1:0]   res_paddr,
  output logic [63:0]       res_pte,
  output logic [ASID_W-1:0] res_asid
);
  localparam int PPN_W = PA_W - 12;
  localparam int VA_W  = 39;
  localparam int IDX_W = 9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic [PA_W-1:0]   base_q;
  logic [1:0]        lvl_q;
  logic [IDX_W-1:0]  idx;

  wire accept = req_valid & req_ready;
  assign req_ready     = (st == S_IDLE) || (st == S_DONE);
  assign res_valid     = (st == S_DONE);
  assign mem_req_valid = (st == S_REQ);

  always_comb begin
    case (lvl_q)
      2'd2:    idx = va_q[38:30];
      2'd1:    idx = va_q[29:21];
      default: idx = va_q[20:12];
    endcase
  end

  assign mem_req_addr = base_q + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};

  wire             pte_v = mem_rsp_data[0];
  wire [2:0]       xwr   = mem_rsp_data[3:1];
  wire [PPN_W-1:0] ppn   = mem_rsp_data[10+PPN_W-1:10];
  wire             unused_bits = ^{mem_rsp_data[63:10+PPN_W], mem_rsp_data[9:4]};

  wire is_ptr   = (xwr == 3'b000);
  wire reserved = xwr[1] & ~xwr[0];
  wire misalign = ((lvl_q == 2'd2) && (|ppn[17:0])) ||
                  ((lvl_q == 2'd1) && (|ppn[8:0]));
  wire fault    = ~pte_v | reserved | (is_ptr && lvl_q == 2'd0) |
                  (~is_ptr && misalign);

  logic [PA_W-1:0] leaf_pa;
  always_comb begin
    case (lvl_q)
      2'd2:    leaf_pa = {ppn[PPN_W-1:18], va_q[29:0]};
      2'd1:    leaf_pa = {ppn[PPN_W-1:9],  va_q[20:0]};
      default: leaf_pa = {ppn, va_q[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      va_q        <= '0;
      asid_q      <= '0;
      base_q      <= '0;
      lvl_q       <= 2'd0;
      res_fault   <= 1'b0;
      res_badmode <= 1'b0;
      res_level   <= 2'd0;
      res_paddr   <= '0;
      res_pte     <= '0;
      res_asid    <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (accept) begin
            va_q   <= req_vaddr;
            asid_q <= ctl_asid;
            if (ctl_mode == 4'd8) begin
              base_q <= {ctl_root_ppn, 12'b0};
              lvl_q  <= 2'd2;
              st     <= S_REQ;
            end else begin
              res_fault   <= (ctl_mode != 4'd0);
              res_badmode <= (ctl_mode != 4'd0);
              res_level   <= 2'd0;
              res_pte     <= '0;
              res_asid    <= ctl_asid;
              res_paddr   <= (ctl_mode == 4'd0) ?
                             {{(PA_W-VA_W){1'b0}}, req_vaddr} : '0;
              st          <= S_DONE;
            end
          end else begin
            st <= S_IDLE;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (!fault && is_ptr) begin
              base_q <= {ppn, 12'b0};
              lvl_q  <= lvl_q - 2'd1;
              st     <= S_REQ;
            end else begin
              res_fault   <= fault;
              res_badmode <= 1'b0;
              res_level   <= lvl_q;
              res_pte     <= mem_rsp_data;
              res_asid    <= asid_q;
              res_paddr   <= fault ? '0 : leaf_pa;
              st          <= S_DONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv39_walker_chk.sv
module sv39_walker_chk #(
  parameter int ASID_W = 16,
  parameter int PA_W   = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [38:0]      req_vaddr,
  input logic [3:0]       ctl_mode,
  input logic [PA_W-13:0] ctl_root_ppn,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             res_valid,
  input logic             res_fault,
  input logic             res_badmode,
  input logic [PA_W-1:0]  res_paddr
);
  logic            pending;
  logic            first_pend;
  logic [PA_W-1:0] first_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      first_pend <= 1'b0;
      first_exp  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) pending <= 1'b1;
      else if (mem_rsp_valid)             pending <= 1'b0;
      if (req_valid && req_ready && ctl_mode == 4'd8) begin
        first_pend <= 1'b1;
        first_exp  <= {ctl_root_ppn, 12'b0} +
                      {{(PA_W-12){1'b0}}, req_vaddr[38:30], 3'b000};
      end else if (mem_req_valid && mem_req_ready) begin
        first_pend <= 1'b0;
      end
    end
  end

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid);
  p_hold_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  p_entry_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  p_root_address_r3: assert property (@(posedge clk) disable iff (!rst_n)
    first_pend && mem_req_valid |-> mem_req_addr == first_exp);
  p_badmode_faults_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_badmode |-> res_fault);
  p_fault_clears_pa_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0);
endmodule

bind sv39_walker sv39_walker_chk #(.ASID_W(ASID_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .ctl_mode(ctl_mode), .ctl_root_ppn(ctl_root_ppn),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .res_valid(res_valid), .res_fault(res_fault), .res_badmode(res_badmode),
  .res_paddr(res_paddr)
);

// File: tb/sv39_walker_tb.sv
`timescale 1ns/1ps
module sv39_walker_tb;
  localparam int ASID_W = 16;
  localparam int PA_W   = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [38:0]       req_vaddr = '0;
  logic [3:0]        ctl_mode = '0;
  logic [ASID_W-1:0] ctl_asid = '0;
  logic [PA_W-13:0]  ctl_root_ppn = '0;
  logic              mem_req_valid;
  logic              mem_req_ready;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid;
  logic [63:0]       mem_rsp_data;
  logic              res_valid, res_fault, res_badmode;
  logic [1:0]        res_level;
  logic [PA_W-1:0]   res_paddr;
  logic [63:0]       res_pte;
  logic [ASID_W-1:0] res_asid;

  sv39_walker #(.ASID_W(ASID_W), .PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .ctl_mode(ctl_mode), .ctl_asid(ctl_asid),
    .ctl_root_ppn(ctl_root_ppn), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_badmode(res_badmode),
    .res_level(res_level), .res_paddr(res_paddr), .res_pte(res_pte),
    .res_asid(res_asid)
  );

  typedef struct packed {
    logic              fault;
    logic              badmode;
    logic [1:0]        lvl;
    logic [PA_W-1:0]   pa;
    logic [63:0]       pte;
    logic [ASID_W-1:0] asid;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, failures = 0, rd_count = 0;
  bit overlap_seen = 0, reported = 0;
  logic [63:0] mem [logic [PA_W-1:0]];

  function automatic logic [63:0] pte(input logic [43:0] ppn, input logic [3:0] xwrv);
    return {10'd0, ppn, 2'b00, 4'hC, xwrv};
  endfunction
  function automatic logic [PA_W-1:0] ea(input logic [43:0] ppn, input logic [8:0] idx);
    return {ppn, 12'b0} + {44'd0, idx, 3'b000};
  endfunction
  function automatic logic [38:0] mkva(input logic [8:0] a, input logic [8:0] b,
                                       input logic [8:0] c, input logic [11:0] off);
    return {a, b, c, off};
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  endtask

  // memory model: acceptance with periodic stalls, response one cycle later
  initial begin
    bit hs_pend = 0;
    logic [PA_W-1:0] hs_addr = '0;
    int stall = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hs_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(hs_addr) ? mem[hs_addr] : 64'd0;
        hs_pend = 0;
      end
      stall++;
      mem_req_ready = (stall % 3) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        hs_pend = 1;
        hs_addr = mem_req_addr;
        rd_count++;
      end
    end
  end

  // monitor: pops scoreboard on each result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && res_valid && req_valid && req_ready) overlap_seen = 1;
      if (rst_n && res_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "unexpected result", $sformatf("pa=%h", res_paddr), "none");
        end else begin
          exp_t e;
          exp_t a;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          a = '{fault: res_fault, badmode: res_badmode, lvl: res_level,
                pa: res_paddr, pte: res_pte, asid: res_asid};
          check(a == e, t,
                $sformatf("f=%0d bm=%0d lvl=%0d pa=%h pte=%h asid=%h",
                          a.fault, a.badmode, a.lvl, a.pa, a.pte, a.asid),
                $sformatf("f=%0d bm=%0d lvl=%0d pa=%h pte=%h asid=%h",
                          e.fault, e.badmode, e.lvl, e.pa, e.pte, e.asid));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    check(0, "watchdog", "timeout", "finish");
    report();
  end

  task automatic issue(input logic [38:0] va, input logic [3:0] mode,
                       input logic [43:0] root, input logic [15:0] asid,
                       input logic f, input logic bm, input logic [1:0] lvl,
                       input logic [PA_W-1:0] pa, input logic [63:0] p, input string t);
    exp_q.push_back('{fault: f, badmode: bm, lvl: lvl, pa: pa, pte: p, asid: asid});
    tag_q.push_back(t);
    req_vaddr    = va;
    ctl_mode     = mode;
    ctl_root_ppn = root;
    ctl_asid     = asid;
    req_valid    = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [38:0] va;
    logic [43:0] p4k, p2m, p1g;
    int c0;
    p4k = 44'h12345;
    p2m = 44'h45600;
    p1g = 44'h0C0000;
    mem[ea(44'h100, 9'h005)] = pte(44'h200, 4'b0001);
    mem[ea(44'h200, 9'h00A)] = pte(44'h300, 4'b0001);
    mem[ea(44'h300, 9'h0F0)] = pte(p4k, 4'b0111);
    mem[ea(44'h200, 9'h011)] = pte(p2m, 4'b1011);
    mem[ea(44'h100, 9'h1F0)] = pte(p1g, 4'b1111);
    mem[ea(44'h200, 9'h022)] = pte(44'h777, 4'b0110);
    mem[ea(44'h100, 9'h007)] = pte(44'h999, 4'b0101);
    mem[ea(44'h300, 9'h0F1)] = pte(44'h555, 4'b1101);
    mem[ea(44'h300, 9'h0F2)] = pte(44'h444, 4'b0001);
    mem[ea(44'h200, 9'h012)] = pte(44'h45601, 4'b0011);
    mem[ea(44'h100, 9'h1F1)] = pte(44'h0C0200, 4'b0011);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!res_valid && !mem_req_valid && req_ready, "reset state",
          $sformatf("rv=%0d mv=%0d rdy=%0d", res_valid, mem_req_valid, req_ready), "rv=0 mv=0 rdy=1");

    c0 = rd_count;
    va = mkva(9'h005, 9'h00A, 9'h0F0, 12'h345);
    issue(va, 4'd8, 44'h100, 16'h0011, 0, 0, 2'd0, {p4k, 12'h345}, pte(p4k, 4'b0111), "R5 R3 4K leaf");
    drain();
    check(rd_count - c0 == 3, "R4 three reads for 4K walk", $sformatf("%0d", rd_count - c0), "3");

    c0 = rd_count;
    va = mkva(9'h005, 9'h011, 9'h1AB, 12'hABC);
    issue(va, 4'd8, 44'h100, 16'h0012, 0, 0, 2'd1, {p2m[43:9], va[20:0]}, pte(p2m, 4'b1011), "R6 2M leaf");
    drain();
    check(rd_count - c0 == 2, "R6 two reads for 2M walk", $sformatf("%0d", rd_count - c0), "2");

    c0 = rd_count;
    va = mkva(9'h1F0, 9'h155, 9'h0AA, 12'h123);
    issue(va, 4'd8, 44'h100, 16'h0013, 0, 0, 2'd2, {p1g[43:18], va[29:0]}, pte(p1g, 4'b1111), "R6 1G leaf");
    drain();
    check(rd_count - c0 == 1, "R6 one read for 1G walk", $sformatf("%0d", rd_count - c0), "1");

    issue(mkva(9'h005, 9'h022, 9'h001, 12'h0), 4'd8, 44'h100, 16'h0014, 1, 0, 2'd1, '0,
          pte(44'h777, 4'b0110), "R7 invalid entry level 1");
    issue(mkva(9'h007, 9'h000, 9'h000, 12'h0), 4'd8, 44'h100, 16'h0015, 1, 0, 2'd2, '0,
          pte(44'h999, 4'b0101), "R8 xwr 010 level 2");
    issue(mkva(9'h005, 9'h00A, 9'h0F1, 12'h0), 4'd8, 44'h100, 16'h0016, 1, 0, 2'd0, '0,
          pte(44'h555, 4'b1101), "R8 xwr 110 level 0");
    issue(mkva(9'h005, 9'h00A, 9'h0F2, 12'h0), 4'd8, 44'h100, 16'h0017, 1, 0, 2'd0, '0,
          pte(44'h444, 4'b0001), "R9 pointer at level 0");
    issue(mkva(9'h005, 9'h012, 9'h000, 12'h0), 4'd8, 44'h100, 16'h0018, 1, 0, 2'd1, '0,
          pte(44'h45601, 4'b0011), "R10 misaligned 2M");
    issue(mkva(9'h1F1, 9'h000, 9'h000, 12'h0), 4'd8, 44'h100, 16'h0019, 1, 0, 2'd2, '0,
          pte(44'h0C0200, 4'b0011), "R10 misaligned 1G");
    drain();

    c0 = rd_count;
    va = 39'h12_3456_789A;
    issue(va, 4'd0, 44'h100, 16'h0020, 0, 0, 2'd0, {17'd0, va}, '0, "R1 bare");
    drain();
    check(rd_count == c0, "R1 bare reads memory", $sformatf("%0d", rd_count - c0), "0");

    c0 = rd_count;
    issue(mkva(9'h005, 9'h00A, 9'h0F0, 12'h0), 4'd9, 44'h100, 16'h0021, 1, 1, 2'd0, '0, '0, "R2 mode 9");
    issue(mkva(9'h005, 9'h00A, 9'h0F0, 12'h0), 4'd1, 44'h100, 16'h0022, 1, 1, 2'd0, '0, '0, "R2 mode 1");
    drain();
    check(rd_count == c0, "R2 unsupported mode reads memory", $sformatf("%0d", rd_count - c0), "0");

    overlap_seen = 0;
    va = mkva(9'h005, 9'h00A, 9'h0F0, 12'h777);
    issue(va, 4'd8, 44'h100, 16'h002A, 0, 0, 2'd0, {p4k, 12'h777}, pte(p4k, 4'b0111), "R12 walk with later ctl change");
    issue(39'h7F_0000_1234, 4'd0, 44'hBAD, 16'h0033, 0, 0, 2'd0, {17'd0, 39'h7F_0000_1234}, '0,
          "R12 bare accepted in result cycle");
    drain();
    check(overlap_seen, "R12 accept in result cycle", $sformatf("%0d", overlap_seen), "1");

    report();
  end
endmodule